// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block looks at a window of up to fifteen instruction bytes from a byte-aligned CISC instruction stream and works out how long the first instruction in that window is. It skips the prefix bytes at the front and records which kinds of prefix it saw. It then finds the opcode. From the opcode it decides whether an addressing postbyte, a scaled-index postbyte, a displacement and an immediate follow. It reports the total byte count, the byte offset of each field, and the operand and address sizes that apply to this instruction.

A mode input sets the default size, 16 or 32 bits. Override prefixes can flip the operand size or the address size for one instruction. Only a subset of one-byte opcodes is decoded: the arithmetic and logic register and immediate forms, the move forms, and the string moves. Any other opcode is flagged as invalid. An instruction whose byte count would pass fifteen is flagged as too long, and no length is given for it.

The caller presents a window together with a valid strobe. One clock edge later the results appear together with an output valid. The results stay unchanged until the next strobe, so a fetch unit can advance its pointer by the reported length at its own pace.

Top module: `insn_len_decoder`

## Requirements
- R1: For an accepted instruction, `outLen` is between 1 and 15. When the computed length would pass 15, or when all 15 window bytes are prefixes, `outTooLong` is 1 and `outLen` is 0.
- R2: The prefix bytes are 26h, 2Eh, 36h, 3Eh, 64h and 65h (segment, `pfxSeg`), F0h (lock, `pfxLock`), F2h and F3h (repeat, `pfxRep`), 66h (operand size, `pfxOpSz`) and 67h (address size, `pfxAdSz`). They may come in any order. A repeated prefix is allowed, and each copy adds one byte to the length. `opcOffset` equals the number of prefix bytes.
- R3: `opSize32` equals `mode32` XOR `pfxOpSz`. A full-size immediate is 4 bytes when `opSize32` is 1 and 2 bytes when it is 0.
- R4: `adSize32` equals `mode32` XOR `pfxAdSz`, and it selects which addressing rules (R7 or R8) apply.
- R5: The byte-width forms 04h/0Ch/…/3Ch, 80h, 83h, C6h and B0h–B7h always carry a 1-byte immediate. The forms 05h/0Dh/…/3Dh, 81h, C7h and B8h–BFh carry a full-size immediate.
- R6: The accumulator-immediate forms (opcode bits 7:6 = 00 with low three bits 100 or 101) and the register-in-opcode moves B0h–BFh have no addressing postbyte.
- R7: With 32-bit addressing, the postbyte fields are mod (bits 7:6) and rm (bits 2:0). mod=11 gives no displacement, mod=01 gives 1 byte, and mod=10 gives 4 bytes. mod=00 with rm=101 gives 4 bytes. rm=100 with mod≠11 adds a second postbyte, and if that byte's base field (bits 2:0) is 101 under mod=00, a 4-byte displacement follows.
- R8: With 16-bit addressing there is never a second postbyte. mod=01 gives a 1-byte displacement, mod=10 gives 2 bytes, mod=00 with rm=110 gives 2 bytes, and every other mod=00 or mod=11 case gives none.
- R9: The results and `outValid` are registered. `outValid` is 1 exactly in the cycle after `inValid` was 1. The result fields keep their values until the next accepted window.
- R10: An opcode outside the subset (for example 0Fh, 90h, F4h) sets `outBadOp` with `outLen` = 0 and `outTooLong` = 0.
- R11: The string moves A4h and A5h are one byte each, plus any prefixes, with no postbyte, displacement or immediate.
- R12: The field offsets follow one chain. `dispOffset` = `opcOffset` + 1 + postbyte count. `immOffset` = `dispOffset` + `dispLen`. `outLen` = `immOffset` + `immLen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Window valid strobe |
| mode32 | input | 1 | Default size: 1 = 32-bit, 0 = 16-bit |
| winBytes | input | 120 | Instruction bytes, byte 0 in bits 7:0 |
| outValid | output | 1 | Results valid (one cycle after inValid) |
| outLen | output | 4 | Instruction length in bytes, 0 on error |
| outTooLong | output | 1 | Length would pass 15, or no opcode in window |
| outBadOp | output | 1 | Opcode outside the decoded subset |
| pfxSeg | output | 1 | A segment override prefix was seen |
| pfxLock | output | 1 | A lock prefix was seen |
| pfxRep | output | 1 | A repeat prefix was seen |
| pfxOpSz | output | 1 | An operand-size prefix was seen |
| pfxAdSz | output | 1 | An address-size prefix was seen |
| opSize32 | output | 1 | Effective operand size is 32 |
| adSize32 | output | 1 | Effective address size is 32 |
| opcOffset | output | 4 | Byte offset of the opcode |
| modrmPresent | output | 1 | An addressing postbyte follows the opcode |
| sibPresent | output | 1 | A scaled-index postbyte follows |
| dispOffset | output | 4 | Byte offset of the displacement field |
| dispLen | output | 3 | Displacement length: 0, 1, 2 or 4 |
| immOffset | output | 4 | Byte offset of the immediate field |
| immLen | output | 3 | Immediate length: 0, 1, 2 or 4 |

## Verification
Each result is due at the first clock edge after the edge that sees `inValid`. The bench changes the window and the strobe on a falling edge. It drops the strobe on the next falling edge and reads every field on that same falling edge, which is half a period after the capturing edge. One more falling edge later it checks that `outValid` has gone low while the length keeps its value. Expected lengths come from hand-encoded instructions, each counted byte by byte, with extra attention to the fifteen-byte limit on both sides.

// File: rtl/ild_pkg.sv
package ild_pkg;
  parameter int unsigned ILD_MAX_LEN = 15;
  localparam int unsigned ILD_WIN_W  = ILD_MAX_LEN * 8;
  localparam int unsigned ILD_OFF_W  = $clog2(ILD_MAX_LEN + 1);

  typedef enum logic [1:0] {IMM_NONE, IMM_BYTE, IMM_FULL} imm_kind_e;

  typedef struct packed {
    logic capture;
  } ild_strobe_t;

  typedef struct packed {
    logic [ILD_OFF_W-1:0] len;
    logic                 tooLong;
    logic                 badOp;
    logic                 pfxSeg;
    logic                 pfxLock;
    logic                 pfxRep;
    logic                 pfxOpSz;
    logic                 pfxAdSz;
    logic                 opSize32;
    logic                 adSize32;
    logic [ILD_OFF_W-1:0] opcOff;
    logic                 hasModrm;
    logic                 hasSib;
    logic [ILD_OFF_W-1:0] dispOff;
    logic [2:0]           dispLen;
    logic [ILD_OFF_W-1:0] immOff;
    logic [2:0]           immLen;
  } ild_result_t;
endpackage

// File: rtl/ild_control.sv
module ild_control
  import ild_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ild_strobe_t strobe,
  output logic        outValid
);
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/ild_datapath.sv
module ild_datapath
  import ild_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ild_strobe_t          strobe,
  input  logic                 mode32,
  input  logic [ILD_WIN_W-1:0] winBytes,
  output ild_result_t          result
);
  function automatic logic [7:0] byteAt(input logic [ILD_WIN_W-1:0] w, input int idx);
    if (idx < int'(ILD_MAX_LEN)) return w[idx*8 +: 8];
    return 8'h00;
  endfunction

  ild_result_t nextRes;
  logic [7:0]  opc, modrmB, sibB;
  logic        unusedBits;
  assign unusedBits = ^{modrmB[5:3], sibB[7:3]};

  always_comb begin
    int        nPfx, postCnt, dispN, immN, dispPos, immPos, total;
    logic      stop, known, seg, lck, rep, osz, asz, op32, ad32, modrm, sib;
    imm_kind_e immKind;

    nPfx = 0; stop = 1'b0;
    seg = 1'b0; lck = 1'b0; rep = 1'b0; osz = 1'b0; asz = 1'b0;
    for (int i = 0; i < int'(ILD_MAX_LEN); i++) begin
      if (!stop) begin
        case (byteAt(winBytes, i))
          8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: begin seg = 1'b1; nPfx++; end
          8'hF0:        begin lck = 1'b1; nPfx++; end
          8'hF2, 8'hF3: begin rep = 1'b1; nPfx++; end
          8'h66:        begin osz = 1'b1; nPfx++; end
          8'h67:        begin asz = 1'b1; nPfx++; end
          default:      stop = 1'b1;
        endcase
      end
    end
    op32 = mode32 ^ osz;
    ad32 = mode32 ^ asz;

    opc    = byteAt(winBytes, nPfx);
    modrmB = byteAt(winBytes, nPfx + 1);
    sibB   = byteAt(winBytes, nPfx + 2);

    known = 1'b1; modrm = 1'b0; immKind = IMM_NONE;
    if (opc[7:6] == 2'b00 && opc[2:1] == 2'b00)      modrm = 1'b1;
    else if (opc[7:6] == 2'b00 && opc[2:0] == 3'd4)  immKind = IMM_BYTE;
    else if (opc[7:6] == 2'b00 && opc[2:0] == 3'd5)  immKind = IMM_FULL;
    else if (opc[7:3] == 5'b10110)                   immKind = IMM_BYTE;
    else if (opc[7:3] == 5'b10111)                   immKind = IMM_FULL;
    else begin
      case (opc)
        8'h80, 8'h83, 8'hC6:             begin modrm = 1'b1; immKind = IMM_BYTE; end
        8'h81, 8'hC7:                    begin modrm = 1'b1; immKind = IMM_FULL; end
        8'h88, 8'h89, 8'h8A, 8'h8B:      modrm = 1'b1;
        8'hA4, 8'hA5:                    ;
        default:                         known = 1'b0;
      endcase
    end

    sib = 1'b0; dispN = 0;
    if (modrm) begin
      if (ad32) begin
        sib = (modrmB[7:6] != 2'b11) && (modrmB[2:0] == 3'b100);
        case (modrmB[7:6])
          2'b01:   dispN = 1;
          2'b10:   dispN = 4;
          2'b00:   dispN = ((modrmB[2:0] == 3'b101) || (sib && sibB[2:0] == 3'b101)) ? 4 : 0;
          default: dispN = 0;
        endcase
      end else begin
        case (modrmB[7:6])
          2'b01:   dispN = 1;
          2'b10:   dispN = 2;
          2'b00:   dispN = (modrmB[2:0] == 3'b110) ? 2 : 0;
          default: dispN = 0;
        endcase
      end
    end

    case (immKind)
      IMM_BYTE: immN = 1;
      IMM_FULL: immN = op32 ? 4 : 2;
      default:  immN = 0;
    endcase

    postCnt = (modrm ? 1 : 0) + (sib ? 1 : 0);
    dispPos = nPfx + 1 + postCnt;
    immPos  = dispPos + dispN;
    total   = immPos + immN;

    nextRes.tooLong  = !stop || (known && total > int'(ILD_MAX_LEN));
    nextRes.badOp    = stop && !known;
    nextRes.len      = (nextRes.tooLong || nextRes.badOp) ? '0 : ILD_OFF_W'(total);
    nextRes.pfxSeg   = seg;
    nextRes.pfxLock  = lck;
    nextRes.pfxRep   = rep;
    nextRes.pfxOpSz  = osz;
    nextRes.pfxAdSz  = asz;
    nextRes.opSize32 = op32;
    nextRes.adSize32 = ad32;
    nextRes.opcOff   = ILD_OFF_W'(nPfx);
    nextRes.hasModrm = modrm;
    nextRes.hasSib   = sib;
    nextRes.dispOff  = ILD_OFF_W'(dispPos);
    nextRes.dispLen  = 3'(dispN);
    nextRes.immOff   = ILD_OFF_W'(immPos);
    nextRes.immLen   = 3'(immN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= nextRes;
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 mode32,
  input  logic [ILD_WIN_W-1:0] winBytes,
  output logic                 outValid,
  output logic [ILD_OFF_W-1:0] outLen,
  output logic                 outTooLong,
  output logic                 outBadOp,
  output logic                 pfxSeg,
  output logic                 pfxLock,
  output logic                 pfxRep,
  output logic                 pfxOpSz,
  output logic                 pfxAdSz,
  output logic                 opSize32,
  output logic                 adSize32,
  output logic [ILD_OFF_W-1:0] opcOffset,
  output logic                 modrmPresent,
  output logic                 sibPresent,
  output logic [ILD_OFF_W-1:0] dispOffset,
  output logic [2:0]           dispLen,
  output logic [ILD_OFF_W-1:0] immOffset,
  output logic [2:0]           immLen
);
  ild_strobe_t strobe;
  ild_result_t res;

  ild_control uCtrl (.clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid));
  ild_datapath uDp (.clk(clk), .rstN(rstN), .strobe(strobe), .mode32(mode32),
                    .winBytes(winBytes), .result(res));

  assign outLen       = res.len;
  assign outTooLong   = res.tooLong;
  assign outBadOp     = res.badOp;
  assign pfxSeg       = res.pfxSeg;
  assign pfxLock      = res.pfxLock;
  assign pfxRep       = res.pfxRep;
  assign pfxOpSz      = res.pfxOpSz;
  assign pfxAdSz      = res.pfxAdSz;
  assign opSize32     = res.opSize32;
  assign adSize32     = res.adSize32;
  assign opcOffset    = res.opcOff;
  assign modrmPresent = res.hasModrm;
  assign sibPresent   = res.hasSib;
  assign dispOffset   = res.dispOff;
  assign dispLen      = res.dispLen;
  assign immOffset    = res.immOff;
  assign immLen       = res.immLen;
endmodule

// File: rtl/ild_checker.sv
module ild_checker
  import ild_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 mode32,
  input logic                 outValid,
  input logic [ILD_OFF_W-1:0] outLen,
  input logic                 outTooLong,
  input logic                 outBadOp,
  input logic                 pfxOpSz,
  input logic                 pfxAdSz,
  input logic                 opSize32,
  input logic                 adSize32,
  input logic                 modrmPresent,
  input logic                 sibPresent,
  input logic [2:0]           dispLen,
  input logic [2:0]           immLen
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outTooLong && !outBadOp) |-> (outLen >= 1 && 32'(outLen) <= ILD_MAX_LEN));
  a_r1_error_len_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outTooLong || outBadOp)) |-> (outLen == '0));
  a_r3_opsize: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (opSize32 == ($past(mode32) ^ pfxOpSz)));
  a_r4_adsize: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (adSize32 == ($past(mode32) ^ pfxAdSz)));
  a_r3_imm_full32: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && immLen == 3'd4) |-> opSize32);
  a_r7_sib_only32: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && sibPresent) |-> (modrmPresent && adSize32));
  a_r8_disp16_only: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dispLen == 3'd2) |-> !adSize32);
endmodule

bind insn_len_decoder ild_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .mode32(mode32), .outValid(outValid),
  .outLen(outLen), .outTooLong(outTooLong), .outBadOp(outBadOp), .pfxOpSz(pfxOpSz),
  .pfxAdSz(pfxAdSz), .opSize32(opSize32), .adSize32(adSize32),
  .modrmPresent(modrmPresent), .sibPresent(sibPresent), .dispLen(dispLen), .immLen(immLen)
);

// File: tb/tb_insn_len_decoder.sv
module tb_insn_len_decoder;
  import ild_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic mode32 = 1'b1;
  logic [ILD_WIN_W-1:0] winBytes = '0;
  logic outValid, outTooLong, outBadOp, pfxSeg, pfxLock, pfxRep, pfxOpSz, pfxAdSz;
  logic opSize32, adSize32, modrmPresent, sibPresent;
  logic [ILD_OFF_W-1:0] outLen, opcOffset, dispOffset, immOffset;
  logic [2:0] dispLen, immLen;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  insn_len_decoder dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Window: nPfx copies of pfx, then body bytes (first byte in the most significant used byte)
  task automatic issue(input logic m, input int nPfx, input logic [7:0] pfx,
                       input logic [119:0] body, input int bodyLen);
    logic [ILD_WIN_W-1:0] w;
    int pos;
    w = '0; pos = 0;
    for (int i = 0; i < nPfx; i++) begin
      if (pos < 15) w[pos*8 +: 8] = pfx;
      pos++;
    end
    for (int i = 0; i < bodyLen; i++) begin
      if (pos < 15) w[pos*8 +: 8] = body[(bodyLen-1-i)*8 +: 8];
      pos++;
    end
    @(negedge clk);
    winBytes = w; mode32 = m; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectLen(input string req, input int len, input int tooLong, input int bad);
    chk(req, "outValid", int'(outValid), 1);
    chk(req, "outLen", int'(outLen), len);
    chk(req, "outTooLong", int'(outTooLong), tooLong);
    chk(req, "outBadOp", int'(outBadOp), bad);
  endtask

  task automatic testReset;
    chk("R9", "reset outValid", int'(outValid), 0);
    chk("R9", "reset outLen", int'(outLen), 0);
  endtask

  task automatic testAluForms;
    issue(1, 0, 8'h00, 120'h01C0, 2);          expectLen("R6", 2, 0, 0);
    chk("R6", "modrm", int'(modrmPresent), 1);
    issue(1, 0, 8'h00, 120'h04AA, 2);          expectLen("R5", 2, 0, 0);
    chk("R6", "no modrm acc", int'(modrmPresent), 0);
    issue(1, 0, 8'h00, 120'h80C011, 3);        expectLen("R5", 3, 0, 0);
    issue(1, 0, 8'h00, 120'h83C011, 3);        expectLen("R5", 3, 0, 0);
    chk("R5", "imm8 len", int'(immLen), 1);
    issue(1, 0, 8'h00, 120'hB011, 2);          expectLen("R6", 2, 0, 0);
    chk("R6", "B0 modrm", int'(modrmPresent), 0);
  endtask

  task automatic testImmSize;
    issue(1, 0, 8'h00, 120'h0511223344, 5);    expectLen("R3", 5, 0, 0);
    issue(1, 1, 8'h66, 120'h051122, 3);        expectLen("R3", 4, 0, 0);
    chk("R3", "opSize32", int'(opSize32), 0);
    issue(1, 0, 8'h00, 120'h81C011223344, 6);  expectLen("R5", 6, 0, 0);
    issue(0, 0, 8'h00, 120'hB81122, 3);        expectLen("R3", 3, 0, 0);
    issue(0, 1, 8'h66, 120'hB811223344, 5);    expectLen("R3", 6, 0, 0);
    chk("R3", "immLen 4", int'(immLen), 4);
  endtask

  task automatic testAddr32;
    issue(1, 0, 8'h00, 120'hC705_11223344_55667788, 10); expectLen("R7", 10, 0, 0);
    chk("R12", "dispOffset", int'(dispOffset), 2);
    chk("R12", "immOffset", int'(immOffset), 6);
    chk("R7", "dispLen", int'(dispLen), 4);
    issue(1, 0, 8'h00, 120'h8B0424, 3);        expectLen("R7", 3, 0, 0);
    chk("R7", "sib", int'(sibPresent), 1);
    issue(1, 0, 8'h00, 120'h8B0425_11223344, 7); expectLen("R7", 7, 0, 0);
    issue(1, 0, 8'h00, 120'h8B442408, 4);      expectLen("R7", 4, 0, 0);
    issue(1, 0, 8'h00, 120'h8B8424_11223344, 7); expectLen("R7", 7, 0, 0);
    issue(1, 0, 8'h00, 120'h8B4508, 3);        expectLen("R7", 3, 0, 0);
    issue(1, 0, 8'h00, 120'h8B05_11223344, 6); expectLen("R7", 6, 0, 0);
    chk("R7", "no sib rm101", int'(sibPresent), 0);
    issue(1, 0, 8'h00, 120'h8B80_11223344, 6); expectLen("R7", 6, 0, 0);
    issue(1, 0, 8'h00, 120'h8BC4, 2);          expectLen("R7", 2, 0, 0);
    chk("R7", "mod11 no sib", int'(sibPresent), 0);
  endtask

  task automatic testAddr16;
    issue(0, 0, 8'h00, 120'h8B061122, 4);      expectLen("R8", 4, 0, 0);
    chk("R8", "dispLen", int'(dispLen), 2);
    issue(0, 0, 8'h00, 120'h8B04, 2);          expectLen("R8", 2, 0, 0);
    chk("R8", "no sib", int'(sibPresent), 0);
    issue(0, 0, 8'h00, 120'h8B4608, 3);        expectLen("R8", 3, 0, 0);
    issue(0, 0, 8'h00, 120'h8B871122, 4);      expectLen("R8", 4, 0, 0);
    issue(1, 1, 8'h67, 120'h8B061122, 4);      expectLen("R4", 5, 0, 0);
    chk("R4", "adSize32", int'(adSize32), 0);
    issue(1, 1, 8'h67, 120'h8B04, 2);          expectLen("R4", 3, 0, 0);
    issue(0, 1, 8'h67, 120'h8B0424, 3);        expectLen("R4", 4, 0, 0);
    chk("R4", "sib via prefix", int'(sibPresent), 1);
  endtask

  task automatic testPrefixes;
    issue(1, 0, 8'h00, 120'hF3A5, 2);          expectLen("R11", 2, 0, 0);
    chk("R2", "pfxRep", int'(pfxRep), 1);
    chk("R11", "immLen", int'(immLen), 0);
    issue(1, 3, 8'h26, 120'hA4, 1);            expectLen("R2", 4, 0, 0);
    chk("R2", "opcOffset", int'(opcOffset), 3);
    chk("R2", "pfxSeg", int'(pfxSeg), 1);
    chk("R2", "pfxLock clear", int'(pfxLock), 0);
    issue(1, 0, 8'h00, 120'hF0_2E_67_66_65_A5, 6); expectLen("R2", 6, 0, 0);
    chk("R2", "pfxLock", int'(pfxLock), 1);
    chk("R2", "pfxOpSz", int'(pfxOpSz), 1);
    chk("R2", "pfxAdSz", int'(pfxAdSz), 1);
    issue(1, 0, 8'h00, 120'hA4, 1);            expectLen("R11", 1, 0, 0);
  endtask

  task automatic testLimit;
    issue(1, 5, 8'h2E, 120'hC705_11223344_55667788, 10); expectLen("R1", 15, 0, 0);
    issue(1, 6, 8'h2E, 120'hC705_11223344_55667788, 10); expectLen("R1", 0, 1, 0);
    issue(1, 14, 8'h3E, 120'hA4, 1);           expectLen("R1", 15, 0, 0);
    issue(1, 15, 8'h3E, 120'h00, 0);           expectLen("R1", 0, 1, 0);
    issue(1, 14, 8'h3E, 120'h8B, 1);           expectLen("R1", 0, 1, 0);
  endtask

  task automatic testBadOp;
    issue(1, 0, 8'h00, 120'h0F05, 2);          expectLen("R10", 0, 0, 1);
    issue(1, 0, 8'h00, 120'h90, 1);            expectLen("R10", 0, 0, 1);
    issue(1, 1, 8'h66, 120'hF4, 1);            expectLen("R10", 0, 0, 1);
  endtask

  task automatic testHold;
    issue(1, 0, 8'h00, 120'h0511223344, 5);    expectLen("R9", 5, 0, 0);
    @(negedge clk);
    chk("R9", "outValid drops", int'(outValid), 0);
    chk("R9", "outLen held", int'(outLen), 5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testAluForms();
    testImmSize();
    testAddr32();
    testAddr16();
    testPrefixes();
    testLimit();
    testBadOp();
    testHold();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule